// File: doc/BRIEF.md
# Asynchronous Byte-Wide Memory Bus Slave Front End

This block sits behind the pins of an asynchronous byte-wide memory port. An external master drives an active-low chip enable, an active-high chip enable, an active-low write strobe, an active-low output enable, an address and a data byte. The block runs on a much faster system clock. It passes every pin through a two-stage synchronizer and watches the sampled levels to find where each bus cycle begins and ends.

A write is framed by the three strobes together. It begins when the last of them becomes active and ends when the first of them drops. So the write strobe, the low chip enable or the high chip enable can each be the signal that closes the cycle. When a write closes, the address and data sampled at that moment become one item on a valid/ready output stream. The item stays on the stream, unchanged, until the consumer accepts it with ready. The block holds one item only. A write that completes while an item is still waiting is discarded, so a consumer that wants every write must keep ready high.

For reads, the block drives a registered enable for the external data bus tristate buffers. This enable is high only while a read is selected and the write strobe is high. A write strobe that falls during a read therefore turns the drivers off a few clocks later.

Top module: `sram_bus_slave`

## Requirements
- R1: During and just after reset, `wr_valid` and `dq_oe` are both 0.
- R2: A write is recognised only if `we_n`=0, `ce1_n`=0 and `ce2`=1 hold together for at least two consecutive synchronized samples. The item carries the `addr` and `din` values present at the pins when the first of the three strobes deasserts.
- R3: A write framed by `we_n` (both enables already active) yields one item with the correct address and data.
- R4: A write framed by `ce1_n` (`we_n` low and `ce2` high already) yields one item with the correct address and data.
- R5: A write framed by `ce2` (`we_n` and `ce1_n` already low) yields one item with the correct address and data. The same holds when the strobes overlap in a staggered order.
- R6: An active write condition that lasts only one system clock produces no item.
- R7: While `wr_valid`=1 and `wr_ready`=0, `wr_addr` and `wr_data` stay stable and `wr_valid` stays 1. The cycle after a handshake, `wr_valid` is 0.
- R8: A write that completes while an item is still waiting is discarded. The waiting item is delivered unchanged.
- R9: `dq_oe` becomes 1 within three clocks of `ce1_n`=0, `ce2`=1, `oe_n`=0 and `we_n`=1 holding at the pins. It is 1 only three clocks after that condition was sampled.
- R10: If `we_n` falls while a read drives the bus, `dq_oe` is 0 within three clocks. A new item first appears three clocks after a pin sample in which the write condition was false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce1_n | input | 1 | Chip enable, active low (asynchronous pin) |
| ce2 | input | 1 | Chip enable, active high (asynchronous pin) |
| we_n | input | 1 | Write strobe, active low (asynchronous pin) |
| oe_n | input | 1 | Output enable, active low (asynchronous pin) |
| addr | input | AW | Memory address pins |
| din | input | DW | Data pins in the write direction |
| wr_valid | output | 1 | A captured write item is available |
| wr_ready | input | 1 | Consumer accepts the item |
| wr_addr | output | AW | Address of the captured write |
| wr_data | output | DW | Data of the captured write |
| dq_oe | output | 1 | Enable for the external data bus tristate drivers |

## Verification
The assertions assume that the master holds `addr` and `din` steady for at least two system clocks after the closing edge of a write. They also assume that `wr_ready` changes only between clock edges and that every strobe pulse meant as a bus cycle spans several clocks. The stimulus changes pins only on falling clock edges. It keeps the data byte valid for three or more clocks on either side of the closing strobe and drives a wrong byte earlier in the cycle, which shows that the capture happens at the end of the cycle. A deliberate one-clock strobe pulse is the only stimulus that breaks the minimum-width rule, and it exists to check R6.

// File: rtl/sram_slv_pkg.sv
package sram_slv_pkg;
  // Minimum number of consecutive synchronized samples for a valid cycle
  localparam int unsigned MIN_ACTIVE = 2;
  // Synchronizer depth
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic we_n;
    logic oe_n;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
  localparam ctl_t CTL_IDLE = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/sram_sync.sv
module sram_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= RST_VAL;
        else     stage[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= RST_VAL;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/sram_cycle_det.sv
module sram_cycle_det
  import sram_slv_pkg::*;
#(
  parameter int unsigned MIN_ACT = MIN_ACTIVE
) (
  input  logic clk,
  input  logic rst,
  input  ctl_t s_ctl,
  output logic wr_done,
  output logic rd_drive
);
  localparam int unsigned CW = $clog2(MIN_ACT + 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_ACT);

  logic          wr_act;
  logic          rd_act;
  logic [CW-1:0] run_cnt;

  // A write is active only with all three strobes asserted together
  assign wr_act = !s_ctl.ce1_n && s_ctl.ce2 && !s_ctl.we_n;
  assign rd_act = !s_ctl.ce1_n && s_ctl.ce2 && !s_ctl.oe_n && s_ctl.we_n;

  // Cycle closes on the first strobe that drops, once long enough
  assign wr_done = !wr_act && (run_cnt == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      rd_drive <= 1'b0;
    end else begin
      rd_drive <= rd_act;
      if (!wr_act)             run_cnt <= '0;
      else if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sram_wr_out.sv
module sram_wr_out #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [AW-1:0] o_addr,
  output logic [DW-1:0] o_data
);
  logic slot_free;

  assign slot_free = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_addr  <= '0;
      o_data  <= '0;
    end else begin
      if (o_valid && o_ready) o_valid <= 1'b0;
      // Only load when no item is waiting; otherwise the new write is lost
      if (take && !o_valid) begin
        o_valid <= 1'b1;
        o_addr  <= cap_addr;
        o_data  <= cap_data;
      end
    end
  end

  logic unused_free;
  assign unused_free = slot_free;
endmodule

// File: rtl/sram_bus_slave.sv
module sram_bus_slave
  import sram_slv_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          dq_oe
);
  localparam int unsigned BW = CTL_W + AW + DW;
  localparam logic [BW-1:0] BUS_RST = {CTL_IDLE, {(AW+DW){1'b0}}};

  ctl_t          s_ctl;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic          wr_done;

  sram_sync #(.W(BW), .DEPTH(SYNC_DEPTH), .RST_VAL(BUS_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ce1_n, ce2, we_n, oe_n, addr, din}),
    .q   ({s_ctl, s_addr, s_data})
  );

  sram_cycle_det #(.MIN_ACT(MIN_ACTIVE)) u_det (
    .clk      (clk),
    .rst      (rst),
    .s_ctl    (s_ctl),
    .wr_done  (wr_done),
    .rd_drive (dq_oe)
  );

  sram_wr_out #(.AW(AW), .DW(DW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .take     (wr_done),
    .cap_addr (s_addr),
    .cap_data (s_data),
    .o_valid  (wr_valid),
    .o_ready  (wr_ready),
    .o_addr   (wr_addr),
    .o_data   (wr_data)
  );
endmodule

// File: rtl/sram_bus_slave_chk.sv
module sram_bus_slave_chk #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ce1_n,
  input logic          ce2,
  input logic          we_n,
  input logic          oe_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          dq_oe
);
  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_drop_after_hs_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_valid);

  assert_oe_only_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!$past(ce1_n, 3) && $past(ce2, 3) && !$past(oe_n, 3) && $past(we_n, 3)));

  assert_oe_off_on_write_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(we_n, 3) |-> !dq_oe);

  assert_item_at_cycle_end_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> ($past(ce1_n, 3) || !$past(ce2, 3) || $past(we_n, 3)));
endmodule

bind sram_bus_slave sram_bus_slave_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce1_n    (ce1_n),
  .ce2      (ce2),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .dq_oe    (dq_oe)
);

// File: tb/test_sram_bus_slave.sv
module test_sram_bus_slave;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce1_n = 1'b1, ce2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic wr_ready = 1'b1;
  logic wr_valid, dq_oe;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [AW+DW-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bus_slave #(.AW(AW), .DW(DW)) i_sram_bus_slave (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .dq_oe(dq_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare every accepted item against the scoreboard
  always @(negedge clk) begin
    if (!rst && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected item", {wr_addr, wr_data}, 32'h0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        check("R2 item", {wr_addr, wr_data}, e);
      end
    end
  end

  // mode 0: we_n frames, 1: ce1_n frames, 2: ce2 frames, 3: staggered overlap
  task automatic write_cyc(input int mode, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input bit expect_item);
    addr = a; din = ~d;
    case (mode)
      0: begin ce1_n = 0; ce2 = 1; clks(2); we_n = 0; end
      1: begin we_n = 0; ce2 = 1; clks(2); ce1_n = 0; end
      2: begin we_n = 0; ce1_n = 0; clks(2); ce2 = 1; end
      default: begin ce2 = 1; clks(1); we_n = 0; clks(1); ce1_n = 0; end
    endcase
    clks(2); din = d; clks(3);
    case (mode)
      0: we_n = 1;
      1: ce1_n = 1;
      default: ce2 = 0;
    endcase
    if (expect_item) exp_q.push_back({a, d});
    clks(3);
    ce1_n = 1; ce2 = 0; we_n = 1; din = 8'h5A;
    clks(4);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clks(3);
    check("R1 valid in reset", wr_valid, 0);
    check("R1 oe in reset", dq_oe, 0);
    rst = 1'b0;
    clks(3);
    check("R1 valid after reset", wr_valid, 0);
    check("R1 oe after reset", dq_oe, 0);

    // R3, R4, R5 framing variants
    write_cyc(0, 13'h0123, 8'hA5, 1);  // R3
    write_cyc(1, 13'h1FF8, 8'h3C, 1);  // R4
    write_cyc(2, 13'h0AAA, 8'hC3, 1);  // R5
    write_cyc(3, 13'h1555, 8'h81, 1);  // R5 overlap
    write_cyc(0, 13'h0000, 8'hFF, 1);  // R3
    clks(4);
    check("R3 R4 R5 scoreboard drained", exp_q.size(), 0);

    // R6: one-clock glitch of the write condition
    ce1_n = 0; ce2 = 1; clks(2);
    we_n = 0; clks(1); we_n = 1;
    clks(6);
    check("R6 glitch no item", wr_valid, 0);
    ce1_n = 1; ce2 = 0; clks(3);

    // R7 and R8: stall the consumer
    wr_ready = 0;
    write_cyc(0, 13'h0777, 8'h42, 1);
    check("R7 valid held", wr_valid, 1);
    check("R7 addr held", wr_addr, 13'h0777);
    check("R7 data held", wr_data, 8'h42);
    write_cyc(1, 13'h0999, 8'h99, 0);  // R8: dropped
    check("R8 pending addr kept", wr_addr, 13'h0777);
    check("R8 pending data kept", wr_data, 8'h42);
    wr_ready = 1;
    clks(1);
    check("R7 valid low after handshake", wr_valid, 0);
    clks(4);
    check("R8 no second item", wr_valid, 0);
    check("R8 scoreboard drained", exp_q.size(), 0);

    // R9: read drive
    ce1_n = 0; ce2 = 1; oe_n = 0;
    clks(4);
    check("R9 oe on read", dq_oe, 1);
    oe_n = 1; clks(4);
    check("R9 oe off when oe_n high", dq_oe, 0);
    oe_n = 0; ce2 = 0; clks(4);
    check("R9 oe off when ce2 low", dq_oe, 0);
    ce2 = 1; clks(4);
    check("R9 oe back on", dq_oe, 1);

    // R10: write strobe during read
    we_n = 0; clks(4);
    check("R10 oe off after we_n falls", dq_oe, 0);
    exp_q.push_back({addr, din});
    we_n = 1; clks(1); oe_n = 1; ce1_n = 1; ce2 = 0;
    clks(6);
    check("R10 scoreboard drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule